// File: doc/BRIEF.md
# Channel Conversion Sequencer with Merged Interrupt

This block sits in a motor-control coprocessor and is steered by one system control word written from the host side. When software asks for a conversion cycle, the block walks through a list of analog channels, presenting one channel at a time to an external converter. It uses a request/acknowledge handshake and drops the request once the last channel has been acknowledged. Which channels make up the list follows from control bits:
- the V and W phases are always converted;
- the U phase is added in front of them when the three-phase bit is set;
- one of four auxiliary inputs is added at the end when the auxiliary bit is set.

The end of a conversion cycle and an external rotation-complete event are merged onto one active-low interrupt line. Each source has its own enable. The line either pulses low for one system clock or stays low until the host reads the status word, which reports the causes and is cleared by that read. A further control bit turns the system clock enable into a divide-by-two strobe. The sequencer and the interrupt logic then advance only on every other clock.

Top module: `conv_seq_irq`

## Requirements
- R1: After reset the control word is all zero, `irq_n` is 1, `conv_req` is 0, `stat_rdata` is 0 and `sys_ce` is 1.
- R2: Control word layout (default `AUX_SEL_W`=2): bits [1:0] pick the auxiliary input, bit 2 enables U, bit 3 enables the auxiliary channel, bit 4 selects divide-by-two, bit 5 enables the conversion-complete interrupt, bit 6 enables the rotation-complete interrupt, and bit 7 selects level mode. With bits 2 and 3 clear, a cycle converts V (code 1) then W (code 2).
- R3: `conv_req` stays high with `conv_chan` unchanged until `conv_ack` is seen. A `cyc_start` during a running cycle is ignored.
- R4: With bit 2 set, the cycle converts U (code 0), then V, then W.
- R5: With bit 3 set, the selected auxiliary input is converted last, with code 4 + select (aux0..aux3 give codes 4..7).
- R6: An event whose enable bit is clear neither pulls `irq_n` low nor sets a status flag.
- R7: In edge mode (bit 7 = 0), an enabled event pulls `irq_n` low for exactly one system clock, starting in the clock after the event (after the final acknowledge for conversion-complete).
- R8: In level mode, an enabled event holds `irq_n` low until `stat_rd` is pulsed. `stat_rdata` bit 0 flags conversion-complete and bit 1 flags rotation-complete. A read clears the flags, and `irq_n` is high in the following clock.
- R9: An enabled event arriving in the same clock as `stat_rd` is kept in the status, and `irq_n` stays low.
- R10: With bit 4 clear, `sys_ce` is always 1. With bit 4 set, `sys_ce` alternates every clock, and an edge-mode interrupt pulse then lasts two clocks.
- R11: The channel list is fixed when a cycle starts. Control writes during a running cycle do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | External clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | CTRL_W (8) | Control word write data |
| stat_rd | input | 1 | Status read strobe, clears flags |
| stat_rdata | output | 2 | Status flags: bit 0 conversion-complete, bit 1 rotation-complete |
| cyc_start | input | 1 | Begin a conversion cycle |
| conv_req | output | 1 | Conversion request to converter |
| conv_chan | output | CH_W (3) | Channel code of current request |
| conv_ack | input | 1 | Converter acknowledge of current channel |
| rot_done | input | 1 | Rotation-complete event |
| irq_n | output | 1 | Active-low interrupt |
| sys_ce | output | 1 | System clock enable |

## Verification
The sequencer is tried with four control patterns:
- the bare default;
- U added;
- the auxiliary channel added without U;
- both added, using a different auxiliary select.

Together these tell apart a wrong start channel, a wrong order and a wrong auxiliary code. A held request with a stray start separates correct holding from a restart. Events are sent with their enables set and clear, in pulse and level modes, and also together with a status read. This distinguishes lost events, stuck lines and pulses that are too long. A control rewrite in the middle of a cycle and a run with the divider on show whether the list is snapshotted and whether the pulse width follows the system clock.

// File: rtl/csi_pkg.sv
package csi_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_U    = 3'd1,
    SQ_V    = 3'd2,
    SQ_W    = 3'd3,
    SQ_A    = 3'd4
  } sq_t;

  localparam int NUM_EV  = 2;
  localparam int EV_CONV = 0;
  localparam int EV_ROT  = 1;
endpackage

// File: rtl/csi_ctrl.sv
module csi_ctrl #(
  parameter int CTRL_W  = 8,
  parameter int DIV_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic              sys_ce
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_n;
  logic              tgl_q, tgl_n;

  always_comb begin
    ctrl_n = wr ? wdata : ctrl_q;
    tgl_n  = ~tgl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      tgl_q  <= tgl_n;
    end
  end

  assign ctrl   = ctrl_q;
  assign sys_ce = ~ctrl_q[DIV_BIT] | tgl_q;
endmodule

// File: rtl/csi_seq.sv
module csi_seq
  import csi_pkg::*;
#(
  parameter int AUX_SEL_W = 2,
  localparam int CH_W = AUX_SEL_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce,
  input  logic                 start,
  input  logic                 u_en,
  input  logic                 aux_en,
  input  logic [AUX_SEL_W-1:0] aux_sel,
  input  logic                 ack,
  output logic                 req,
  output logic [CH_W-1:0]      chan,
  output logic                 done
);
  localparam logic [CH_W-1:0] CODE_U = CH_W'(0);
  localparam logic [CH_W-1:0] CODE_V = CH_W'(1);
  localparam logic [CH_W-1:0] CODE_W = CH_W'(2);

  sq_t                  st_q, st_n;
  logic                 aux_en_q, aux_en_n;
  logic [AUX_SEL_W-1:0] sel_q, sel_n;

  always_comb begin
    st_n     = st_q;
    aux_en_n = aux_en_q;
    sel_n    = sel_q;
    done     = 1'b0;
    if (ce) begin
      unique case (st_q)
        SQ_IDLE: if (start) begin
          aux_en_n = aux_en;
          sel_n    = aux_sel;
          st_n     = u_en ? SQ_U : SQ_V;
        end
        SQ_U: if (ack) st_n = SQ_V;
        SQ_V: if (ack) st_n = SQ_W;
        SQ_W: if (ack) begin
          if (aux_en_q) begin
            st_n = SQ_A;
          end else begin
            st_n = SQ_IDLE;
            done = 1'b1;
          end
        end
        SQ_A: if (ack) begin
          st_n = SQ_IDLE;
          done = 1'b1;
        end
        default: st_n = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      aux_en_q <= 1'b0;
      sel_q    <= '0;
    end else begin
      st_q     <= st_n;
      aux_en_q <= aux_en_n;
      sel_q    <= sel_n;
    end
  end

  always_comb begin
    unique case (st_q)
      SQ_U:    chan = CODE_U;
      SQ_V:    chan = CODE_V;
      SQ_W:    chan = CODE_W;
      SQ_A:    chan = {1'b1, sel_q};
      default: chan = CODE_U;
    endcase
  end

  assign req = (st_q != SQ_IDLE);
endmodule

// File: rtl/csi_irq.sv
module csi_irq #(
  parameter int NEV = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] en,
  input  logic           lvl,
  input  logic           rd,
  output logic [NEV-1:0] flags,
  output logic           irq_n
);
  logic [NEV-1:0] fire;
  logic [NEV-1:0] flag_q, flag_n;
  logic           pls_q, pls_n;

  for (genvar i = 0; i < NEV; i++) begin : g_ev
    always_comb begin
      fire[i]   = ev[i] & en[i] & ce;
      flag_n[i] = (flag_q[i] & ~rd) | fire[i];
    end
  end

  always_comb begin
    pls_n = ce ? (|fire) : pls_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      pls_q  <= 1'b0;
    end else begin
      flag_q <= flag_n;
      pls_q  <= pls_n;
    end
  end

  assign flags = flag_q;
  assign irq_n = lvl ? ~(|flag_q) : ~pls_q;
endmodule

// File: rtl/conv_seq_irq.sv
module conv_seq_irq
  import csi_pkg::*;
#(
  parameter int AUX_SEL_W = 2,
  localparam int CH_W   = AUX_SEL_W + 1,
  localparam int CTRL_W = AUX_SEL_W + 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              stat_rd,
  output logic [1:0]        stat_rdata,
  input  logic              cyc_start,
  output logic              conv_req,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_ack,
  input  logic              rot_done,
  output logic              irq_n,
  output logic              sys_ce
);
  localparam int B_UEN  = AUX_SEL_W;
  localparam int B_AEN  = AUX_SEL_W + 1;
  localparam int B_DIV  = AUX_SEL_W + 2;
  localparam int B_CIEN = AUX_SEL_W + 3;
  localparam int B_RIEN = AUX_SEL_W + 4;
  localparam int B_LVL  = AUX_SEL_W + 5;

  logic              rs_meta, rs_sync;
  logic [CTRL_W-1:0] ctrl;
  logic              seq_done;
  logic [NUM_EV-1:0] ev, en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  csi_ctrl #(.CTRL_W(CTRL_W), .DIV_BIT(B_DIV)) u_ctrl (
    .clk(clk), .rst_n(rs_sync), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .ctrl(ctrl), .sys_ce(sys_ce)
  );

  csi_seq #(.AUX_SEL_W(AUX_SEL_W)) u_seq (
    .clk(clk), .rst_n(rs_sync), .ce(sys_ce), .start(cyc_start),
    .u_en(ctrl[B_UEN]), .aux_en(ctrl[B_AEN]), .aux_sel(ctrl[AUX_SEL_W-1:0]),
    .ack(conv_ack), .req(conv_req), .chan(conv_chan), .done(seq_done)
  );

  always_comb begin
    ev          = '0;
    en          = '0;
    ev[EV_CONV] = seq_done;
    ev[EV_ROT]  = rot_done;
    en[EV_CONV] = ctrl[B_CIEN];
    en[EV_ROT]  = ctrl[B_RIEN];
  end

  csi_irq #(.NEV(NUM_EV)) u_irq (
    .clk(clk), .rst_n(rs_sync), .ce(sys_ce), .ev(ev), .en(en),
    .lvl(ctrl[B_LVL]), .rd(stat_rd), .flags(stat_rdata), .irq_n(irq_n)
  );
endmodule

// File: rtl/csi_chk.sv
module csi_chk #(
  parameter int AUX_SEL_W = 2,
  localparam int CH_W   = AUX_SEL_W + 1,
  localparam int CTRL_W = AUX_SEL_W + 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic              stat_rd,
  input logic [CTRL_W-1:0] ctrl,
  input logic              conv_req,
  input logic [CH_W-1:0]   conv_chan,
  input logic              conv_ack,
  input logic              rot_done,
  input logic              irq_n,
  input logic              sys_ce
);
  localparam int B_DIV  = AUX_SEL_W + 2;
  localparam int B_CIEN = AUX_SEL_W + 3;
  localparam int B_RIEN = AUX_SEL_W + 4;
  localparam int B_LVL  = AUX_SEL_W + 5;

  // R3: request and channel hold until accepted
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !(conv_ack && sys_ce) |=> conv_req && $stable(conv_chan));

  // R4: U is followed by V, V by W
  a_r4_u_then_v: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_ack && sys_ce && conv_chan == CH_W'(0) |=> conv_req && conv_chan == CH_W'(1));
  a_r4_v_then_w: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_ack && sys_ce && conv_chan == CH_W'(1) |=> conv_req && conv_chan == CH_W'(2));

  // R6: the line only falls after an enabled event or a control write
  a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(ctrl_wr) || $past(rot_done && ctrl[B_RIEN]) || $past(conv_ack && ctrl[B_CIEN]));

  // R7: edge mode pulse ends after one clock without new events
  a_r7_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[B_LVL] && !ctrl[B_DIV] && !irq_n && !rot_done && !conv_ack && !ctrl_wr |=> irq_n);

  // R8: level mode holds until read
  a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[B_LVL] && !irq_n && !stat_rd && !ctrl_wr |=> !irq_n);

  // R10: enable pattern
  a_r10_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[B_DIV] && sys_ce && !ctrl_wr |=> !sys_ce);
  a_r10_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[B_DIV] && !ctrl_wr |=> sys_ce);
endmodule

bind conv_seq_irq csi_chk #(.AUX_SEL_W(AUX_SEL_W)) u_csi_chk (
  .clk(clk), .rst_n(rs_sync), .ctrl_wr(ctrl_wr), .stat_rd(stat_rd),
  .ctrl(ctrl), .conv_req(conv_req), .conv_chan(conv_chan),
  .conv_ack(conv_ack), .rot_done(rot_done), .irq_n(irq_n), .sys_ce(sys_ce)
);

// File: tb/test_conv_seq_irq.sv
module test_conv_seq_irq;
  localparam int C_UEN = 4, C_AEN = 8, C_DIV = 16, C_CIEN = 32, C_RIEN = 64, C_LVL = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic       stat_rd = 1'b0;
  logic [1:0] stat_rdata;
  logic       cyc_start = 1'b0;
  logic       conv_req;
  logic [2:0] conv_chan;
  logic       conv_ack = 1'b0;
  logic       rot_done = 1'b0;
  logic       irq_n;
  logic       sys_ce;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  conv_seq_irq i_conv_seq_irq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .stat_rdata(stat_rdata), .cyc_start(cyc_start),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_ack(conv_ack),
    .rot_done(rot_done), .irq_n(irq_n), .sys_ce(sys_ce)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_ctrl(input int v);
    ctrl_wdata = 8'(v);
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic read_stat(input string tag, input int exp);
    check(tag, int'(stat_rdata), exp);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic run_cycle(input string tag, input int n, input int e[4], input bit exp_low);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      check({tag, " req"}, int'(conv_req), 1);
      check({tag, " chan"}, int'(conv_chan), e[k]);
      conv_ack = 1'b1;
      @(negedge clk);
      conv_ack = 1'b0;
    end
    check({tag, " req end"}, int'(conv_req), 0);
    check({tag, " irq"}, int'(irq_n), exp_low ? 0 : 1);
    @(negedge clk);
    check({tag, " irq after"}, int'(irq_n), 1);
  endtask

  task automatic t_reset();
    check("R1 irq_n", int'(irq_n), 1);
    check("R1 conv_req", int'(conv_req), 0);
    check("R1 stat", int'(stat_rdata), 0);
    check("R1 sys_ce", int'(sys_ce), 1);
  endtask

  task automatic t_default();
    run_cycle("R2 default", 2, '{1, 2, 0, 0}, 1'b0);
    check("R6 no status when disabled", int'(stat_rdata), 0);
  endtask

  task automatic t_hold();
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3 hold req", int'(conv_req), 1);
      check("R3 hold chan", int'(conv_chan), 1);
    end
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    check("R3 start ignored", int'(conv_chan), 1);
    conv_ack = 1'b1;
    @(negedge clk);
    check("R3 next chan", int'(conv_chan), 2);
    @(negedge clk);
    conv_ack = 1'b0;
    check("R3 done", int'(conv_req), 0);
  endtask

  task automatic t_u_edge();
    write_ctrl(C_UEN | C_CIEN);
    run_cycle("R4 R7 U phase", 3, '{0, 1, 2, 0}, 1'b1);
    read_stat("R8 conv flag", 1);
    check("R8 cleared", int'(stat_rdata), 0);
  endtask

  task automatic t_aux();
    write_ctrl(C_AEN | 2);
    run_cycle("R5 aux2", 3, '{1, 2, 6, 0}, 1'b0);
    write_ctrl(C_AEN | C_UEN | 3);
    run_cycle("R5 aux3", 4, '{0, 1, 2, 7}, 1'b0);
  endtask

  task automatic t_disabled();
    write_ctrl(C_CIEN | C_LVL);
    rot_done = 1'b1;
    @(negedge clk);
    rot_done = 1'b0;
    check("R6 rot disabled irq", int'(irq_n), 1);
    check("R6 rot disabled stat", int'(stat_rdata), 0);
  endtask

  task automatic t_level();
    write_ctrl(C_RIEN | C_LVL);
    rot_done = 1'b1;
    @(negedge clk);
    rot_done = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check("R8 held low", int'(irq_n), 0);
      @(negedge clk);
    end
    read_stat("R8 rot flag", 2);
    check("R8 released", int'(irq_n), 1);
    check("R8 stat clear", int'(stat_rdata), 0);
  endtask

  task automatic t_collide();
    write_ctrl(C_RIEN | C_CIEN | C_LVL);
    rot_done = 1'b1;
    @(negedge clk);
    rot_done = 1'b1;
    stat_rd = 1'b1;
    @(negedge clk);
    rot_done = 1'b0;
    stat_rd = 1'b0;
    check("R9 kept stat", int'(stat_rdata), 2);
    check("R9 kept irq", int'(irq_n), 0);
    read_stat("R9 second read", 2);
    check("R9 released", int'(irq_n), 1);
  endtask

  task automatic t_snapshot();
    write_ctrl(C_UEN);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
    ctrl_wdata = 8'(C_AEN);
    ctrl_wr = 1'b1;
    check("R11 first", int'(conv_chan), 0);
    conv_ack = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
    check("R11 second", int'(conv_chan), 1);
    @(negedge clk);
    check("R11 third", int'(conv_chan), 2);
    @(negedge clk);
    conv_ack = 1'b0;
    check("R11 no aux", int'(conv_req), 0);
  endtask

  task automatic t_div();
    int lows;
    int ces;
    write_ctrl(C_DIV | C_RIEN);
    ces = 0;
    for (int k = 0; k < 8; k++) begin
      ces += int'(sys_ce);
      @(negedge clk);
    end
    check("R10 half rate", ces, 4);
    rot_done = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rot_done = 1'b0;
    lows = (irq_n == 1'b0) ? 1 : 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      lows += (irq_n == 1'b0) ? 1 : 0;
    end
    check("R10 pulse two clocks", lows, 2);
    write_ctrl(0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 full rate", int'(sys_ce), 1);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_default();
    t_hold();
    t_u_edge();
    t_aux();
    t_disabled();
    t_level();
    t_collide();
    t_snapshot();
    t_div();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule